// File: doc/BRIEF.md
# Single-Entry Loop Branch Predictor

This block sits between the execute stage and the instruction fetch address generator of an in-order core. The core fetches one 32-bit word per accepted request and supports 16-bit compressed instructions. The block holds exactly one prediction: the most recent taken branch whose offset points backwards. Tight loops close on such branches. Each outgoing fetch address is compared against the word that holds the last halfword of that branch. On a match, the word after it is fetched from the branch target instead of from the next sequential word. This removes the redirect bubble on every iteration after the first.

Every fetched word carries a two-bit halfword-valid mask and a predicted-branch flag toward decode. The mask has bit 0 for the lower halfword and bit 1 for the upper halfword. The execute stage reports each resolved branch back to the block, together with whether that branch was tagged as predicted. The block returns whether execute must redirect fetch and where to. For a predicted branch the sense of the condition is inverted and the offset becomes the instruction length. A redirect on a predicted branch is therefore a misprediction, and it returns fetch to the fall-through address. A parameter removes the predictor while keeping the same ports.

Top module: `loop_btb`

## Requirements
- R1: After reset the entry is invalid, `fetch_addr` equals `RESET_ADDR`, `data_hw_valid` is 2'b11 and `data_pred` is 0.
- R2: When execute reports a taken, unpredicted branch with a negative offset (sign bit of `ex_imm_hw` set), the entry becomes valid and stores that branch. An unpredicted taken branch redirects to `ex_pc` plus the offset.
- R3: The stored source is the address of the branch's last halfword: `ex_pc`+2 for a 32-bit branch and `ex_pc` for a 16-bit branch. A 32-bit branch at an address with bit 1 set therefore hits on the following word.
- R4: `fetch_hit` is 1 only when the entry is valid and fetch address bits [31:2] equal stored source bits [31:2].
- R5: When a hitting fetch is accepted and no core jump is present, the next `fetch_addr` is the stored target with bits [1:0] cleared. Otherwise an accepted fetch advances by 4.
- R6: On an accepted hitting fetch whose source has address bit 1 clear, that word's `data_hw_valid` has bit 1 (upper halfword) cleared.
- R7: If the target has address bit 1 set, the next accepted word has `data_hw_valid` bit 0 (lower halfword) cleared. The same applies to a core jump whose address has bit 1 set.
- R8: `data_pred` of each accepted word equals whether that fetch hit.
- R9: For a branch tagged predicted, the condition is inverted and the offset is 4 (32-bit) or 2 (16-bit). A raw not-taken result redirects to the fall-through address, and a raw taken result gives no redirect.
- R10: The entry becomes invalid after `ex_fence_i`, after `trap_accept`, or after a predicted branch that redirects. An allocation in the same cycle wins over a clear.
- R11: A core jump in the same cycle as an accepted hitting fetch sets the next `fetch_addr` to the jump word.
- R12: With `ENABLE`=0, `fetch_hit` and `data_pred` stay 0, the predictor never clears a mask bit, and `ex_pred` has no effect on the redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_accept | input | 1 | Current fetch address accepted by the bus |
| core_jump_vld | input | 1 | Core-level redirect of fetch |
| core_jump_hw | input | ADDR_W-1 | Jump address bits [31:1] |
| fetch_addr | output | ADDR_W | Word-aligned fetch address |
| fetch_hit | output | 1 | Current fetch address matches the stored branch |
| data_hw_valid | output | 2 | Halfword-valid mask of the last accepted word (bit0 lower) |
| data_pred | output | 1 | Last accepted word holds a predicted-taken branch |
| ex_branch | input | 1 | A branch resolves in execute this cycle |
| ex_pc_hw | input | ADDR_W-1 | Branch address bits [31:1] |
| ex_is_32b | input | 1 | Branch is a 32-bit instruction |
| ex_imm_hw | input | ADDR_W-1 | Branch immediate bits [31:1], sign-extended |
| ex_cond | input | 1 | Raw branch condition result |
| ex_pred | input | 1 | Branch was tagged as predicted at fetch |
| ex_fence_i | input | 1 | Instruction-fence in execute |
| trap_accept | input | 1 | Trap entry accepted |
| ex_redirect | output | 1 | Execute must redirect fetch |
| ex_redirect_addr | output | ADDR_W | Redirect address |

## Verification
The loop pattern allocates on a backward branch and runs two iterations. The first shows allocation and redirect. The second shows a steady-state hit, and the exit shows that one inverted-condition redirect clears the entry. Four allocations cross source-halfword parity with target-halfword parity, so each mask bit is tied to the correct address bit. A 32-bit branch that straddles a word boundary separates source = PC from source = PC+2. Same-cycle fence-plus-allocate and jump-plus-hit show the two priority orders. A second instance with the predictor disabled receives identical stimulus and must never hit or tag.

// File: rtl/loop_btb_pkg.sv
package loop_btb_pkg;
    typedef logic [1:0] hw_mask_t;   // bit0 lower halfword, bit1 upper
    localparam hw_mask_t HW_BOTH = 2'b11;
endpackage

// File: rtl/lbp_entry.sv
module lbp_entry #(
    parameter int ADDR_W = 32,
    parameter int ENABLE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic [ADDR_W-2:0] set_src_i,
    input  logic [ADDR_W-2:0] set_tgt_i,
    input  logic              clear_i,
    output logic              valid_o,
    output logic [ADDR_W-2:0] src_o,
    output logic [ADDR_W-2:0] tgt_o
);
    localparam int HW_W = ADDR_W - 1;

    generate
        if (ENABLE != 0) begin : g_on
            typedef struct packed {
                logic            valid;
                logic [HW_W-1:0] src;
                logic [HW_W-1:0] tgt;
            } entry_t;

            entry_t ent_d, ent_q;

            always_comb begin
                ent_d = ent_q;
                if (set_i) begin
                    ent_d.valid = 1'b1;
                    ent_d.src   = set_src_i;
                    ent_d.tgt   = set_tgt_i;
                end else if (clear_i) begin
                    ent_d.valid = 1'b0;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ent_q <= '0;
                else        ent_q <= ent_d;
            end

            assign valid_o = ent_q.valid;
            assign src_o   = ent_q.src;
            assign tgt_o   = ent_q.tgt;

            AST_ALLOC_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
                set_i |=> valid_o && src_o == $past(set_src_i) && tgt_o == $past(set_tgt_i)); // R2
            AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                clear_i && !set_i |=> !valid_o); // R10
        end else begin : g_off
            assign valid_o = 1'b0;
            assign src_o   = '0;
            assign tgt_o   = '0;
        end
    endgenerate
endmodule

// File: rtl/lbp_resolve.sv
module lbp_resolve #(
    parameter int ADDR_W = 32,
    parameter int ENABLE = 1
) (
    input  logic              ex_branch,
    input  logic [ADDR_W-2:0] ex_pc_hw,
    input  logic              ex_is_32b,
    input  logic [ADDR_W-2:0] ex_imm_hw,
    input  logic              ex_cond,
    input  logic              ex_pred,
    input  logic              ex_fence_i,
    input  logic              trap_accept,
    output logic              redirect_o,
    output logic [ADDR_W-1:0] redirect_addr_o,
    output logic              set_o,
    output logic [ADDR_W-2:0] set_src_o,
    output logic [ADDR_W-2:0] set_tgt_o,
    output logic              clear_o
);
    localparam int HW_W = ADDR_W - 1;

    logic            pred_eff;
    logic [HW_W-1:0] off_hw;
    logic [HW_W-1:0] sum_hw;
    logic            take;

    always_comb begin
        pred_eff = (ENABLE != 0) && ex_pred;
        if (pred_eff) off_hw = ex_is_32b ? HW_W'(2) : HW_W'(1);
        else          off_hw = ex_imm_hw;
        sum_hw    = ex_pc_hw + off_hw;
        take      = ex_branch && (ex_cond ^ pred_eff);
        set_o     = take && ex_imm_hw[HW_W-1] && !pred_eff;
        clear_o   = ex_fence_i || trap_accept || (pred_eff && take);
        set_src_o = ex_pc_hw + (ex_is_32b ? HW_W'(1) : HW_W'(0));
        set_tgt_o = sum_hw;
        redirect_o      = take;
        redirect_addr_o = {sum_hw, 1'b0};
    end
endmodule

// File: rtl/lbp_fetch.sv
module lbp_fetch
    import loop_btb_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    parameter int                ENABLE     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              jump_vld_i,
    input  logic [ADDR_W-2:0] jump_hw_i,
    input  logic              ent_valid_i,
    input  logic [ADDR_W-2:0] ent_src_i,
    input  logic [ADDR_W-2:0] ent_tgt_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              hit_o,
    output hw_mask_t          data_mask_o,
    output logic              data_pred_o
);
    localparam int HW_W   = ADDR_W - 1;
    localparam int WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        hw_mask_t          aph_mask;
        hw_mask_t          data_mask;
        logic              data_pred;
    } fetch_t;

    fetch_t st_d, st_q;
    logic   hit;

    always_comb begin
        hit  = (ENABLE != 0) && ent_valid_i && (st_q.word == ent_src_i[HW_W-1:1]);
        st_d = st_q;
        if (accept_i) begin
            st_d.data_mask = st_q.aph_mask & {~(hit & ~ent_src_i[0]), 1'b1};
            st_d.data_pred = hit;
            st_d.aph_mask  = {1'b1, ~(hit & ent_tgt_i[0])};
            st_d.word      = hit ? ent_tgt_i[HW_W-1:1] : st_q.word + WORD_W'(1);
        end
        if (jump_vld_i) begin
            st_d.word     = jump_hw_i[HW_W-1:1];
            st_d.aph_mask = {1'b1, ~jump_hw_i[0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word      <= RESET_ADDR[ADDR_W-1:2];
            st_q.aph_mask  <= HW_BOTH;
            st_q.data_mask <= HW_BOTH;
            st_q.data_pred <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_addr_o = {st_q.word, 2'b00};
    assign hit_o        = hit;
    assign data_mask_o  = st_q.data_mask;
    assign data_pred_o  = st_q.data_pred;

    AST_HIT_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i && hit_o && !jump_vld_i |=> fetch_addr_o[ADDR_W-1:2] == $past(ent_tgt_i[HW_W-1:1])); // R5
    AST_JUMP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        jump_vld_i |=> fetch_addr_o[ADDR_W-1:2] == $past(jump_hw_i[HW_W-1:1])); // R11
    AST_TAG_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> data_pred_o == $past(hit_o)); // R8
    AST_UPPER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i && hit_o && !ent_src_i[0] |=> !data_mask_o[1]); // R6
endmodule

// File: rtl/loop_btb.sv
module loop_btb
    import loop_btb_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_0100,
    parameter int                ENABLE     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_accept,
    input  logic              core_jump_vld,
    input  logic [ADDR_W-2:0] core_jump_hw,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_hit,
    output logic [1:0]        data_hw_valid,
    output logic              data_pred,
    input  logic              ex_branch,
    input  logic [ADDR_W-2:0] ex_pc_hw,
    input  logic              ex_is_32b,
    input  logic [ADDR_W-2:0] ex_imm_hw,
    input  logic              ex_cond,
    input  logic              ex_pred,
    input  logic              ex_fence_i,
    input  logic              trap_accept,
    output logic              ex_redirect,
    output logic [ADDR_W-1:0] ex_redirect_addr
);
    localparam int HW_W = ADDR_W - 1;

    logic            set_w, clear_w, valid_w;
    logic [HW_W-1:0] set_src_w, set_tgt_w, src_w, tgt_w;
    hw_mask_t        mask_w;

    lbp_resolve #(.ADDR_W(ADDR_W), .ENABLE(ENABLE)) u_resolve (
        .ex_branch      (ex_branch),
        .ex_pc_hw       (ex_pc_hw),
        .ex_is_32b      (ex_is_32b),
        .ex_imm_hw      (ex_imm_hw),
        .ex_cond        (ex_cond),
        .ex_pred        (ex_pred),
        .ex_fence_i     (ex_fence_i),
        .trap_accept    (trap_accept),
        .redirect_o     (ex_redirect),
        .redirect_addr_o(ex_redirect_addr),
        .set_o          (set_w),
        .set_src_o      (set_src_w),
        .set_tgt_o      (set_tgt_w),
        .clear_o        (clear_w)
    );

    lbp_entry #(.ADDR_W(ADDR_W), .ENABLE(ENABLE)) u_entry (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_w),
        .set_src_i(set_src_w),
        .set_tgt_i(set_tgt_w),
        .clear_i  (clear_w),
        .valid_o  (valid_w),
        .src_o    (src_w),
        .tgt_o    (tgt_w)
    );

    lbp_fetch #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR), .ENABLE(ENABLE)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (fetch_accept),
        .jump_vld_i  (core_jump_vld),
        .jump_hw_i   (core_jump_hw),
        .ent_valid_i (valid_w),
        .ent_src_i   (src_w),
        .ent_tgt_i   (tgt_w),
        .fetch_addr_o(fetch_addr),
        .hit_o       (fetch_hit),
        .data_mask_o (mask_w),
        .data_pred_o (data_pred)
    );

    assign data_hw_valid = mask_w;

    AST_ALLOC_BACKWARD: assert property (@(posedge clk) disable iff (!rst_n)
        set_w |-> ex_imm_hw[HW_W-1] && ex_redirect); // R2

    generate
        if (ENABLE != 0) begin : g_chk_on
            AST_PRED_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
                ex_branch && ex_pred && !ex_cond |->
                    ex_redirect && ex_redirect_addr ==
                    {ex_pc_hw + (ex_is_32b ? HW_W'(2) : HW_W'(1)), 1'b0}); // R9
        end else begin : g_chk_off
            AST_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
                !fetch_hit && !data_pred); // R12
        end
    endgenerate
endmodule

// File: tb/test_loop_btb.sv
module test_loop_btb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_accept = 1'b0, core_jump_vld = 1'b0;
    logic [30:0] core_jump_hw = '0;
    logic        ex_branch = 1'b0, ex_is_32b = 1'b0, ex_cond = 1'b0, ex_pred = 1'b0;
    logic        ex_fence_i = 1'b0, trap_accept = 1'b0;
    logic [30:0] ex_pc_hw = '0, ex_imm_hw = '0;

    logic [31:0] fetch_addr, ex_redirect_addr, fetch_addr_off, ex_redirect_addr_off;
    logic        fetch_hit, data_pred, ex_redirect;
    logic        fetch_hit_off, data_pred_off, ex_redirect_off;
    logic [1:0]  data_hw_valid, data_hw_valid_off;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    loop_btb i_loop_btb (
        .clk(clk), .rst_n(rst_n), .fetch_accept(fetch_accept),
        .core_jump_vld(core_jump_vld), .core_jump_hw(core_jump_hw),
        .fetch_addr(fetch_addr), .fetch_hit(fetch_hit),
        .data_hw_valid(data_hw_valid), .data_pred(data_pred),
        .ex_branch(ex_branch), .ex_pc_hw(ex_pc_hw), .ex_is_32b(ex_is_32b),
        .ex_imm_hw(ex_imm_hw), .ex_cond(ex_cond), .ex_pred(ex_pred),
        .ex_fence_i(ex_fence_i), .trap_accept(trap_accept),
        .ex_redirect(ex_redirect), .ex_redirect_addr(ex_redirect_addr));

    loop_btb #(.ENABLE(0)) i_loop_btb_off (
        .clk(clk), .rst_n(rst_n), .fetch_accept(fetch_accept),
        .core_jump_vld(core_jump_vld), .core_jump_hw(core_jump_hw),
        .fetch_addr(fetch_addr_off), .fetch_hit(fetch_hit_off),
        .data_hw_valid(data_hw_valid_off), .data_pred(data_pred_off),
        .ex_branch(ex_branch), .ex_pc_hw(ex_pc_hw), .ex_is_32b(ex_is_32b),
        .ex_imm_hw(ex_imm_hw), .ex_cond(ex_cond), .ex_pred(ex_pred),
        .ex_fence_i(ex_fence_i), .trap_accept(trap_accept),
        .ex_redirect(ex_redirect_off), .ex_redirect_addr(ex_redirect_addr_off));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_jump(input logic [31:0] a);
        core_jump_vld = 1'b1; core_jump_hw = a[31:1];
        step();
        core_jump_vld = 1'b0;
    endtask

    task automatic do_accept();
        fetch_accept = 1'b1;
        step();
        fetch_accept = 1'b0;
    endtask

    // Drives one resolved branch; checks the combinational redirect first.
    task automatic branch(input logic [31:0] pc, input logic is32, input logic [31:0] imm,
                          input logic cond, input logic pred,
                          input logic exp_redir, input logic [31:0] exp_addr, input string req);
        ex_branch = 1'b1; ex_pc_hw = pc[31:1]; ex_is_32b = is32;
        ex_imm_hw = imm[31:1]; ex_cond = cond; ex_pred = pred;
        #1;
        chk(req, {31'd0, ex_redirect}, {31'd0, exp_redir});
        if (exp_redir) chk(req, ex_redirect_addr, exp_addr);
        step();
        ex_branch = 1'b0; ex_pred = 1'b0; ex_cond = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 fetch_addr", fetch_addr, 32'h100);
        chk("R1 hit", {31'd0, fetch_hit}, 0);
        chk("R1 mask", {30'd0, data_hw_valid}, 32'd3);
        chk("R1 pred", {31'd0, data_pred}, 0);
    endtask

    task automatic t_loop();
        branch(32'h108, 1'b1, -32'sd8, 1'b1, 1'b0, 1'b1, 32'h100, "R2 alloc redirect");
        do_jump(32'h100);
        chk("R4 other word no hit", {31'd0, fetch_hit}, 0);
        do_accept(); do_accept();
        chk("R2 hit first iteration", {31'd0, fetch_hit}, 1);
        chk("R12 off no hit", {31'd0, fetch_hit_off}, 0);
        do_accept();
        chk("R5 redirect to target", fetch_addr, 32'h100);
        chk("R8 tag set", {31'd0, data_pred}, 1);
        chk("R6 odd source keeps upper", {30'd0, data_hw_valid}, 32'd3);
        chk("R12 off sequential", fetch_addr_off, 32'h10C);
        chk("R12 off tag", {31'd0, data_pred_off}, 0);
        do_accept();
        chk("R8 tag clear", {31'd0, data_pred}, 0);
        chk("R5 sequential", fetch_addr, 32'h104);
        do_accept();
        chk("R2 hit second iteration", {31'd0, fetch_hit}, 1);
        // correctly predicted taken: raw taken, inverted -> no redirect, stays valid
        branch(32'h108, 1'b1, -32'sd8, 1'b1, 1'b1, 1'b0, 32'h0, "R9 predicted correct");
        chk("R10 still valid", {31'd0, fetch_hit}, 1);
        // loop exit: raw not taken on a predicted branch
        ex_branch = 1'b1; ex_pc_hw = 31'h84; ex_is_32b = 1'b1; ex_imm_hw = 31'h7FFF_FFFC;
        ex_cond = 1'b0; ex_pred = 1'b1;
        #1;
        chk("R12 off ignores pred", {31'd0, ex_redirect_off}, 0);
        ex_branch = 1'b0; ex_pred = 1'b0;
        branch(32'h108, 1'b1, -32'sd8, 1'b0, 1'b1, 1'b1, 32'h10C, "R9 mispredict fallthrough");
        chk("R10 mispredict clears", {31'd0, fetch_hit}, 0);
    endtask

    task automatic t_masks(input logic is32, input logic [31:0] imm,
                           input logic [1:0] m1, input logic [1:0] m2, input logic [31:0] tw);
        branch(32'h208, is32, imm, 1'b1, 1'b0, 1'b1, 32'h208 + imm, "R2 alloc");
        do_jump(32'h208);
        chk("R4 hit", {31'd0, fetch_hit}, 1);
        do_accept();
        chk("R6 source mask", {30'd0, data_hw_valid}, {30'd0, m1});
        chk("R12 off mask", {30'd0, data_hw_valid_off}, 32'd3);
        chk("R5 target word", fetch_addr, tw);
        do_accept();
        chk("R7 target mask", {30'd0, data_hw_valid}, {30'd0, m2});
    endtask

    task automatic t_src_addr();
        branch(32'h20E, 1'b1, -32'sd14, 1'b1, 1'b0, 1'b1, 32'h200, "R3 alloc");
        do_jump(32'h20C);
        chk("R3 branch word no hit", {31'd0, fetch_hit}, 0);
        do_accept();
        chk("R3 last-halfword word hits", {31'd0, fetch_hit}, 1);
    endtask

    task automatic t_clears();
        branch(32'h208, 1'b0, -32'sd8, 1'b1, 1'b0, 1'b1, 32'h200, "R2 alloc");
        do_jump(32'h208);
        ex_fence_i = 1'b1; step(); ex_fence_i = 1'b0;
        chk("R10 fence clears", {31'd0, fetch_hit}, 0);
        branch(32'h208, 1'b0, -32'sd8, 1'b1, 1'b0, 1'b1, 32'h200, "R2 alloc");
        chk("R2 realloc hit", {31'd0, fetch_hit}, 1);
        trap_accept = 1'b1; step(); trap_accept = 1'b0;
        chk("R10 trap clears", {31'd0, fetch_hit}, 0);
        ex_fence_i = 1'b1;
        branch(32'h208, 1'b0, -32'sd8, 1'b1, 1'b0, 1'b1, 32'h200, "R10 set with fence");
        ex_fence_i = 1'b0;
        chk("R10 set beats clear", {31'd0, fetch_hit}, 1);
        // forward taken branch must not allocate over a cleared entry
        trap_accept = 1'b1; step(); trap_accept = 1'b0;
        branch(32'h208, 1'b0, 32'd16, 1'b1, 1'b0, 1'b1, 32'h218, "R2 forward");
        chk("R2 forward no alloc", {31'd0, fetch_hit}, 0);
    endtask

    task automatic t_jump_priority();
        branch(32'h208, 1'b0, -32'sd8, 1'b1, 1'b0, 1'b1, 32'h200, "R2 alloc");
        do_jump(32'h208);
        chk("R11 hit before", {31'd0, fetch_hit}, 1);
        fetch_accept = 1'b1; core_jump_vld = 1'b1; core_jump_hw = 31'h180;
        step();
        fetch_accept = 1'b0; core_jump_vld = 1'b0;
        chk("R11 jump wins", fetch_addr, 32'h300);
        do_jump(32'h302);
        do_accept();
        chk("R7 odd jump lower masked", {30'd0, data_hw_valid}, 32'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_loop();
        t_masks(1'b0, -32'sd8, 2'b01, 2'b11, 32'h200);  // src even, tgt even
        t_masks(1'b0, -32'sd6, 2'b01, 2'b10, 32'h200);  // src even, tgt odd
        t_masks(1'b1, -32'sd8, 2'b11, 2'b11, 32'h200);  // src odd,  tgt even
        t_masks(1'b1, -32'sd6, 2'b11, 2'b10, 32'h200);  // src odd,  tgt odd
        t_src_addr();
        t_clears();
        t_jump_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule